// File: doc/BRIEF.md
# Unaligned Access Bus Adapter

The adapter sits between a core load/store port and a 32-bit memory bus that only accepts whole, word-aligned transactions. The core asks for 1, 2 or 4 bytes at any byte address. The adapter turns each request into the word reads and writes the bus can carry. A load that stays inside one word takes a single bus read. A load that crosses a word boundary takes a read of the lower word and then a read of the upper word. The wanted bytes are shifted down and joined into a zero-extended, right-justified result.

Stores always use read-modify-write. Each word the store touches is read first. The new bytes are merged into the old contents, and then each word is written back with byte enables on the lanes that changed. A trap-mode input makes any multi-byte access that is not naturally aligned fail at once, with no bus traffic. An illegal size always fails the same way, whatever the mode.

Top module: `unaligned_bus_adapter`

## Requirements
- R1: The bus carries only a word index (byte address bits 1:0 are never driven). Every bus read drives byte enable 4'b1111.
- R2: A load that lies inside one aligned word makes exactly one bus read, of word addr[31:2]. The bytes come back right-justified; for example, a 2-byte load at byte address 5 returns bytes 5 and 6 of memory in bits 15:0.
- R3: A load that crosses a word boundary makes exactly two bus reads: word addr[31:2] first, then the next word. The result holds the bytes in ascending byte-address order, starting at bit 0.
- R4: Load results are zero-extended. Bits above 8*size are 0, and a store or a faulted request returns rsp_rdata_o = 0.
- R5: A store inside one word makes one read and then one write of the same word. The write enables exactly the lanes of the stored bytes (bit i = byte i of the word), and the word written keeps the old value of every other byte.
- R6: A store that crosses a word boundary issues four bus transactions in this order: read lower word, read upper word, write lower word, write upper word. Each write enables only its own stored lanes.
- R7: A 1-byte access never faults and never makes more than one read (plus one write for a store), in either mode.
- R8: With trap_mode_i = 1, a 2-byte access with addr[0] = 1 or a 4-byte access with addr[1:0] != 0 responds with rsp_fault_o = 1 and makes no bus transaction. Aligned accesses still work normally in this mode.
- R9: Legal sizes are 1, 2 and 4. Any other value of req_size_i responds with rsp_fault_o = 1 and makes no bus transaction, whatever the mode.
- R10: req_ready_o is 1 only when the adapter is idle. Each accepted request gets exactly one rsp_valid_o pulse, one cycle long, after the last bus acknowledge. req_ready_o returns to 1 in the following cycle.
- R11: Once bus_req_o is raised, it stays high until bus_ack_i, and the address, write flag, byte enables and write data stay unchanged meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_mode_i | input | 1 | 1: misaligned multi-byte access faults |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Adapter can accept a request |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Byte address |
| req_size_i | input | 3 | Byte count (1, 2 or 4 legal) |
| req_wdata_i | input | 32 | Store data, right-justified |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Zero-extended load result |
| rsp_fault_o | output | 1 | Misalignment or illegal size fault |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | Bus write |
| bus_addr_o | output | 30 | Word index |
| bus_be_o | output | 4 | Byte enables |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ack_i | input | 1 | Bus acknowledge, read data valid |
| bus_rdata_i | input | 32 | Bus read data |

## Verification
Two things can fall in the same cycle: the final bus acknowledge of an access, and a new request that the core has held valid the whole time. The adapter must not accept the new request until after the response pulse. The bench provokes this with a zero-wait bus, where the acknowledge arrives in the same cycle as the request, and with an access whose second read gets extra wait states. It then judges each access by how many bus transactions the access produced, in what order, and whether req_ready_o stayed low until the cycle after rsp_valid_o.

// File: rtl/uba_pkg.sv
package uba_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_WR0,
    ST_WR1,
    ST_RESP
  } uba_state_e;
endpackage

// File: rtl/uba_decode.sv
module uba_decode #(
  parameter int BYTES  = 4,
  parameter int SIZE_W = 3,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]   off_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic               trap_i,
  output logic               spans_o,
  output logic               fault_o,
  output logic [2*BYTES-1:0] mask_o
);
  localparam int SUM_W = SIZE_W + 1;

  logic [SIZE_W-1:0] sz_m1;
  logic              size_ok;
  logic              misal;
  logic [SUM_W-1:0]  end_pos;

  assign sz_m1   = size_i - SIZE_W'(1);
  assign size_ok = (size_i != '0) && (size_i <= SIZE_W'(BYTES)) && ((size_i & sz_m1) == '0);
  assign misal   = size_ok && ((off_i & sz_m1[OFF_W-1:0]) != '0);
  assign end_pos = SUM_W'(off_i) + SUM_W'(size_i);
  assign spans_o = size_ok && (end_pos > SUM_W'(BYTES));
  assign fault_o = !size_ok || (trap_i && misal);

  // lane i of the two-word window is touched when off <= i < off+size
  for (genvar i = 0; i < 2*BYTES; i++) begin : g_mask
    assign mask_o[i] = size_ok && (SUM_W'(i) >= SUM_W'(off_i)) && (SUM_W'(i) < end_pos);
  end
endmodule

// File: rtl/uba_lane_merge.sv
module uba_lane_merge #(
  parameter int BYTES = 4,
  localparam int OFF_W = $clog2(BYTES),
  localparam int DW    = BYTES * 8
) (
  input  logic [OFF_W-1:0]   off_i,
  input  logic [2*BYTES-1:0] mask_i,
  input  logic [DW-1:0]      word_lo_i,
  input  logic [DW-1:0]      word_hi_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      load_o,
  output logic [DW-1:0]      store_lo_o,
  output logic [DW-1:0]      store_hi_o
);
  logic [2*DW-1:0]    pair;
  logic [2*DW-1:0]    pair_dn;
  logic [2*DW-1:0]    new_up;
  logic [2*DW-1:0]    merged;
  logic [2*BYTES-1:0] mask_dn;
  logic [BYTES-1:0]   keep;

  assign pair    = {word_hi_i, word_lo_i};
  assign pair_dn = pair >> {off_i, 3'b000};
  assign new_up  = {{DW{1'b0}}, wdata_i} << {off_i, 3'b000};
  assign mask_dn = mask_i >> off_i;
  assign keep    = mask_dn[BYTES-1:0];

  for (genvar i = 0; i < BYTES; i++) begin : g_load
    assign load_o[8*i +: 8] = keep[i] ? pair_dn[8*i +: 8] : 8'h00;
  end

  for (genvar j = 0; j < 2*BYTES; j++) begin : g_store
    assign merged[8*j +: 8] = mask_i[j] ? new_up[8*j +: 8] : pair[8*j +: 8];
  end

  assign store_lo_o = merged[DW-1:0];
  assign store_hi_o = merged[2*DW-1:DW];
endmodule

// File: rtl/uba_ctrl.sv
module uba_ctrl
  import uba_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic acc_fault_i,
  input  logic we_q_i,
  input  logic spans_q_i,
  input  logic bus_ack_i,
  output logic accept_o,
  output logic req_ready_o,
  output logic bus_req_o,
  output logic bus_we_o,
  output logic use_hi_o,
  output logic cap_lo_o,
  output logic cap_hi_o,
  output logic rsp_valid_o
);
  uba_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = acc_fault_i ? ST_RESP : ST_RD0;
      ST_RD0:  if (bus_ack_i) state_d = spans_q_i ? ST_RD1 : (we_q_i ? ST_WR0 : ST_RESP);
      ST_RD1:  if (bus_ack_i) state_d = we_q_i ? ST_WR0 : ST_RESP;
      ST_WR0:  if (bus_ack_i) state_d = spans_q_i ? ST_WR1 : ST_RESP;
      ST_WR1:  if (bus_ack_i) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign bus_req_o   = (state_q == ST_RD0) || (state_q == ST_RD1) ||
                       (state_q == ST_WR0) || (state_q == ST_WR1);
  assign bus_we_o    = (state_q == ST_WR0) || (state_q == ST_WR1);
  assign use_hi_o    = (state_q == ST_RD1) || (state_q == ST_WR1);
  assign cap_lo_o    = (state_q == ST_RD0) && bus_ack_i;
  assign cap_hi_o    = (state_q == ST_RD1) && bus_ack_i;
  assign rsp_valid_o = (state_q == ST_RESP);
endmodule

// File: rtl/unaligned_bus_adapter.sv
module unaligned_bus_adapter #(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  parameter int SIZE_W = 3,
  localparam int OFF_W = $clog2(BYTES),
  localparam int DW    = BYTES * 8,
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              rsp_fault_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [WA_W-1:0]   bus_addr_o,
  output logic [BYTES-1:0]  bus_be_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DW-1:0]     bus_rdata_i
);
  logic               dec_spans, dec_fault;
  logic [2*BYTES-1:0] dec_mask;
  logic               accept, use_hi, cap_lo, cap_hi;

  logic [WA_W-1:0]    wa_q;
  logic [OFF_W-1:0]   off_q;
  logic               we_q, spans_q, fault_q;
  logic [DW-1:0]      wdata_q, lo_q, hi_q;
  logic [2*BYTES-1:0] mask_q;
  logic [DW-1:0]      load_data, store_lo, store_hi;

  uba_decode #(.BYTES(BYTES), .SIZE_W(SIZE_W)) u_decode (
    .off_i   (req_addr_i[OFF_W-1:0]),
    .size_i  (req_size_i),
    .trap_i  (trap_mode_i),
    .spans_o (dec_spans),
    .fault_o (dec_fault),
    .mask_o  (dec_mask)
  );

  uba_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .acc_fault_i (dec_fault),
    .we_q_i      (we_q),
    .spans_q_i   (spans_q),
    .bus_ack_i   (bus_ack_i),
    .accept_o    (accept),
    .req_ready_o (req_ready_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .use_hi_o    (use_hi),
    .cap_lo_o    (cap_lo),
    .cap_hi_o    (cap_hi),
    .rsp_valid_o (rsp_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_q    <= '0;
      off_q   <= '0;
      we_q    <= 1'b0;
      spans_q <= 1'b0;
      fault_q <= 1'b0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      wa_q    <= req_addr_i[ADDR_W-1:OFF_W];
      off_q   <= req_addr_i[OFF_W-1:0];
      we_q    <= req_we_i;
      spans_q <= dec_spans;
      fault_q <= dec_fault;
      wdata_q <= req_wdata_i;
      mask_q  <= dec_mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= bus_rdata_i;
      if (cap_hi) hi_q <= bus_rdata_i;
    end
  end

  uba_lane_merge #(.BYTES(BYTES)) u_merge (
    .off_i      (off_q),
    .mask_i     (mask_q),
    .word_lo_i  (lo_q),
    .word_hi_i  (hi_q),
    .wdata_i    (wdata_q),
    .load_o     (load_data),
    .store_lo_o (store_lo),
    .store_hi_o (store_hi)
  );

  // upper word wraps modulo the word address space
  assign bus_addr_o  = wa_q + WA_W'(use_hi);
  assign bus_be_o    = !bus_we_o ? {BYTES{1'b1}} :
                       (use_hi ? mask_q[2*BYTES-1:BYTES] : mask_q[BYTES-1:0]);
  assign bus_wdata_o = !bus_we_o ? '0 : (use_hi ? store_hi : store_lo);

  assign rsp_fault_o = rsp_valid_o && fault_q;
  assign rsp_rdata_o = (rsp_valid_o && !we_q && !fault_q) ? load_data : '0;
endmodule

// File: rtl/uba_checker.sv
module uba_checker #(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  parameter int SIZE_W = 3,
  localparam int OFF_W = $clog2(BYTES),
  localparam int DW    = BYTES * 8,
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trap_mode_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_we_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [SIZE_W-1:0] req_size_i,
  input logic [DW-1:0]     req_wdata_i,
  input logic              rsp_valid_o,
  input logic [DW-1:0]     rsp_rdata_o,
  input logic              rsp_fault_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [WA_W-1:0]   bus_addr_o,
  input logic [BYTES-1:0]  bus_be_o,
  input logic [DW-1:0]     bus_wdata_o,
  input logic              bus_ack_i,
  input logic [DW-1:0]     bus_rdata_i
);
  logic              acc;
  logic              legal;
  logic              we_l;
  logic [SIZE_W-1:0] size_l;

  assign acc   = req_valid_i && req_ready_o;
  assign legal = (req_size_i == SIZE_W'(1)) || (req_size_i == SIZE_W'(2)) ||
                 (req_size_i == SIZE_W'(4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_l   <= 1'b0;
      size_l <= '0;
    end else if (acc) begin
      we_l   <= req_we_i;
      size_l <= req_size_i;
    end
  end

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) &&
                                $stable(bus_be_o) && $stable(bus_wdata_o));

  a_r10_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_req_o && !rsp_valid_o);

  a_r10_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  a_r9_illegal_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !legal |=> !bus_req_o && rsp_valid_o && rsp_fault_o);

  a_r8_trap_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && trap_mode_i && (req_size_i == SIZE_W'(2)) && req_addr_i[0] |=>
      !bus_req_o && rsp_fault_o);

  a_r1_read_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o |-> bus_be_o == {BYTES{1'b1}});

  a_r4_byte_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !we_l && (size_l == SIZE_W'(1)) |-> rsp_rdata_o[DW-1:8] == '0);

  a_r4_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_valid_o && rsp_rdata_o == '0);

  a_r6_write_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> bus_be_o != '0);
endmodule

bind unaligned_bus_adapter uba_checker #(.ADDR_W(ADDR_W), .BYTES(BYTES), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/unaligned_bus_adapter_bench.sv
module unaligned_bus_adapter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trap_mode_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_we_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [2:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        rsp_fault_o;
  logic        bus_req_o, bus_we_o, bus_ack_i;
  logic [29:0] bus_addr_o;
  logic [3:0]  bus_be_o;
  logic [31:0] bus_wdata_o, bus_rdata_i;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  unaligned_bus_adapter u_unaligned_bus_adapter (.*);

  // bus memory model with programmable wait states
  logic [31:0] mem [16];
  int          wait_cyc = 0;
  int          wcnt = 0;
  int          tcnt = 0;
  logic        log_we [64];
  logic [29:0] log_addr [64];
  logic [3:0]  log_be [64];

  assign bus_ack_i   = bus_req_o && (wcnt >= wait_cyc);
  assign bus_rdata_i = mem[bus_addr_o[3:0]];

  always @(posedge clk_i) begin
    if (bus_req_o && !bus_ack_i) wcnt <= wcnt + 1;
    else                         wcnt <= 0;
    if (bus_ack_i) begin
      log_we[tcnt % 64]   <= bus_we_o;
      log_addr[tcnt % 64] <= bus_addr_o;
      log_be[tcnt % 64]   <= bus_be_o;
      tcnt <= tcnt + 1;
      if (bus_we_o)
        for (int b = 0; b < 4; b++)
          if (bus_be_o[b]) mem[bus_addr_o[3:0]][8*b +: 8] <= bus_wdata_o[8*b +: 8];
    end
  end

  // R11: request must hold until acknowledged
  logic        prev_wait = 1'b0;
  logic [29:0] prev_addr = '0;
  always @(negedge clk_i) begin
    if (rst_ni && prev_wait && !(bus_req_o && bus_addr_o == prev_addr)) begin
      failures++;
      $display("FAIL R11 request dropped act=%0b/%h exp=1/%h", bus_req_o, bus_addr_o, prev_addr);
    end
    prev_wait = bus_req_o && !bus_ack_i;
    prev_addr = bus_addr_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic we, input logic [31:0] addr, input logic [2:0] sz,
                           input logic [31:0] wd, output logic [31:0] rd, output logic flt,
                           output int n0, output int ntr);
    int bad;
    @(negedge clk_i);
    req_we_i = we; req_addr_i = addr; req_size_i = sz; req_wdata_i = wd; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    n0 = tcnt;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    bad = 0;
    while (!rsp_valid_o) begin
      if (req_ready_o) bad++;
      @(negedge clk_i);
    end
    if (req_ready_o) bad++;
    rd = rsp_rdata_o; flt = rsp_fault_o; ntr = tcnt - n0;
    @(negedge clk_i);
    if (rsp_valid_o || !req_ready_o) bad++;
    chk(bad == 0, "R10 ready low while busy, single pulse", bad, 0);
  endtask

  task automatic t_reset();
    chk(req_ready_o && !bus_req_o && !rsp_valid_o, "R10 reset state",
        {req_ready_o, bus_req_o, rsp_valid_o}, 3'b100);
  endtask

  task automatic t_inword_load();
    logic [31:0] rd; logic f; int n0, nt;
    wait_cyc = 0; trap_mode_i = 0;
    do_access(0, 32'd5, 3'd2, 0, rd, f, n0, nt);
    chk(rd == 32'h0000_3322 && !f, "R2 halfword at 5", rd, 32'h3322);
    chk(nt == 1 && log_addr[n0%64] == 30'd1 && log_be[n0%64] == 4'hF && !log_we[n0%64],
        "R1 R2 one read word 1", nt, 1);
    do_access(0, 32'd7, 3'd1, 0, rd, f, n0, nt);
    chk(rd == 32'h0000_0044 && nt == 1 && !f, "R4 R7 byte at 7 zero-extended", rd, 32'h44);
  endtask

  task automatic t_span_load();
    logic [31:0] rd; logic f; int n0, nt;
    wait_cyc = 2; trap_mode_i = 0;
    do_access(0, 32'd1, 3'd4, 0, rd, f, n0, nt);
    chk(rd == 32'h11DD_CCBB && !f, "R3 word at 1", rd, 32'h11DDCCBB);
    chk(nt == 2 && log_addr[n0%64] == 30'd0 && log_addr[(n0+1)%64] == 30'd1,
        "R3 two reads lower then upper", nt, 2);
    wait_cyc = 0;
    do_access(0, 32'd3, 3'd2, 0, rd, f, n0, nt);
    chk(rd == 32'h0000_11DD && nt == 2, "R3 R4 halfword at 3", rd, 32'h11DD);
    do_access(0, 32'd8, 3'd4, 0, rd, f, n0, nt);
    chk(rd == 32'h8877_6655 && nt == 1, "R2 aligned word at 8", rd, 32'h88776655);
    do_access(0, 32'd10, 3'd2, 0, rd, f, n0, nt);
    chk(rd == 32'h0000_8877, "R4 upper half zero", rd, 32'h8877);
  endtask

  task automatic t_inword_store();
    logic [31:0] rd; logic f; int n0, nt;
    wait_cyc = 1; trap_mode_i = 0;
    do_access(1, 32'd9, 3'd2, 32'hFFFF_BEEF, rd, f, n0, nt);
    chk(mem[2] == 32'h88BE_EF55, "R5 merged word 2", mem[2], 32'h88BEEF55);
    chk(nt == 2 && !log_we[n0%64] && log_we[(n0+1)%64] && log_be[(n0+1)%64] == 4'b0110 &&
        log_addr[(n0+1)%64] == 30'd2, "R5 read then write be 0110", log_be[(n0+1)%64], 4'b0110);
    chk(rd == 0 && !f, "R4 store returns zero", rd, 0);
    do_access(1, 32'd3, 3'd1, 32'h0000_00A5, rd, f, n0, nt);
    chk(mem[0] == 32'hA5CC_BBAA && nt == 2 && log_be[(n0+1)%64] == 4'b1000,
        "R7 byte store one read one write", mem[0], 32'hA5CCBBAA);
  endtask

  task automatic t_span_store();
    logic [31:0] rd; logic f; int n0, nt;
    wait_cyc = 0; trap_mode_i = 0;
    do_access(1, 32'd14, 3'd4, 32'hA1B2_C3D4, rd, f, n0, nt);
    chk(mem[3] == 32'hC3D4_0A09, "R6 lower word", mem[3], 32'hC3D40A09);
    chk(mem[4] == 32'h100F_A1B2, "R6 upper word", mem[4], 32'h100FA1B2);
    chk(nt == 4 && !log_we[n0%64] && log_addr[n0%64] == 30'd3 &&
        !log_we[(n0+1)%64] && log_addr[(n0+1)%64] == 30'd4 &&
        log_we[(n0+2)%64] && log_addr[(n0+2)%64] == 30'd3 && log_be[(n0+2)%64] == 4'b1100 &&
        log_we[(n0+3)%64] && log_addr[(n0+3)%64] == 30'd4 && log_be[(n0+3)%64] == 4'b0011,
        "R6 order rd3 rd4 wr3 wr4", nt, 4);
  endtask

  task automatic t_trap();
    logic [31:0] rd; logic f; int n0, nt;
    wait_cyc = 0; trap_mode_i = 1;
    do_access(0, 32'd5, 3'd2, 0, rd, f, n0, nt);
    chk(f && nt == 0 && rd == 0, "R8 halfword at 5 faults", {f, 8'(nt)}, 9'h100);
    do_access(1, 32'd18, 3'd4, 32'h1234_5678, rd, f, n0, nt);
    chk(f && nt == 0 && mem[4] == 32'h100F_A1B2, "R8 word store at 18 faults", mem[4], 32'h100FA1B2);
    do_access(0, 32'd4, 3'd4, 0, rd, f, n0, nt);
    chk(!f && nt == 1 && rd == 32'h4433_2211, "R8 aligned word ok", rd, 32'h44332211);
    do_access(0, 32'd7, 3'd1, 0, rd, f, n0, nt);
    chk(!f && nt == 1 && rd == 32'h44, "R7 byte in trap mode", rd, 32'h44);
    trap_mode_i = 0;
  endtask

  task automatic t_illegal();
    logic [31:0] rd; logic f; int n0, nt;
    wait_cyc = 0; trap_mode_i = 0;
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2 || s == 4) continue;
      do_access(1, 32'd4, 3'(s), 32'hFFFF_FFFF, rd, f, n0, nt);
      chk(f && nt == 0 && rd == 0 && mem[1] == 32'h4433_2211, "R9 illegal size faults",
          {f, 8'(nt)}, 9'h100);
    end
  endtask

  initial begin
    mem[0] = 32'hDDCC_BBAA; mem[1] = 32'h4433_2211; mem[2] = 32'h8877_6655;
    mem[3] = 32'h0C0B_0A09; mem[4] = 32'h100F_0E0D;
    for (int i = 5; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_inword_load();
    t_span_load();
    t_inword_store();
    t_span_store();
    t_trap();
    t_illegal();
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule